// File: doc/BRIEF.md
# Add/Subtract Unit with Comparison Flags

This block is a purely combinational two's complement arithmetic unit of parameterised word size (32 bits by default). A one-bit select chooses between A plus B and A minus B. Both operations go through one adder. For subtraction, B is inverted on its way into the adder and the adder carry-in is forced high. The result is kept to the word size, and the bit that falls off the top shows up only as the carry flag.

The unit also produces four condition bits: zero, negative, carry and overflow. When subtraction is selected, it decodes those four bits into ten comparison outcomes, six signed and four unsigned. A caller that wants to compare two words drives them as A and B, selects subtract, and reads whichever relation it needs. The caller needs no separate comparator.

Top module: `asu_addsub_cmp`

## Requirements
- R1: With `sub_sel`=0, `sum` equals (A + B) modulo 2^WIDTH.
- R2: With `sub_sel`=1, `sum` equals (A - B) modulo 2^WIDTH, formed as A + ~B + 1 in the same adder.
- R3: `flag_z` is 1 exactly when every bit of `sum` is 0.
- R4: `flag_n` equals bit WIDTH-1 of `sum`.
- R5: `flag_c` is the carry out of the top bit of the adder. For addition this is bit WIDTH of the full-precision A + B. For subtraction it is 1 exactly when A >= B as unsigned numbers.
- R6: `flag_v` is 1 when the signed result does not fit in WIDTH bits. The rule is evaluated on the operand actually applied to the adder, which is ~B for subtraction.
- R7: With `sub_sel`=1, the signed outputs `cmp_lt`, `cmp_le`, `cmp_eq`, `cmp_ne`, `cmp_ge` and `cmp_gt` match A<B, A<=B, A==B, A!=B, A>=B and A>B with both operands read as two's complement. They are decoded as N^V, Z|(N^V), Z, ~Z, ~(N^V) and ~(Z|(N^V)).
- R8: With `sub_sel`=1, the unsigned outputs `cmp_ltu`, `cmp_leu`, `cmp_geu` and `cmp_gtu` match the unsigned relations. They are decoded as ~C, ~C|Z, C and ~(~C|Z).
- R9: All outputs follow the inputs without any clock. With both operands at zero and addition selected, `sum`=0, Z=1 and N=C=V=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| sub_sel | input | 1 | 0 selects A+B, 1 selects A-B |
| sum | output | WIDTH | Result modulo 2^WIDTH |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result sign bit |
| flag_c | output | 1 | Carry out of the top bit |
| flag_v | output | 1 | Signed overflow |
| cmp_lt | output | 1 | Signed A<B (subtract only) |
| cmp_le | output | 1 | Signed A<=B (subtract only) |
| cmp_eq | output | 1 | A==B (subtract only) |
| cmp_ne | output | 1 | A!=B (subtract only) |
| cmp_ge | output | 1 | Signed A>=B (subtract only) |
| cmp_gt | output | 1 | Signed A>B (subtract only) |
| cmp_ltu | output | 1 | Unsigned A<B (subtract only) |
| cmp_leu | output | 1 | Unsigned A<=B (subtract only) |
| cmp_geu | output | 1 | Unsigned A>=B (subtract only) |
| cmp_gtu | output | 1 | Unsigned A>B (subtract only) |

## Verification
The cases hardest to reach are subtractions where the overflow flag flips the sign comparison. One example is the most negative value minus one. Another is the most positive value minus all ones. Both are cases where applying the overflow rule to the original B instead of ~B gives the wrong answer. Random operands almost never land there, so the stimulus sweeps every ordered pair from a set of corner words: zero, one, the most positive value, the most negative value, all ones and a mixed pattern. Each pair is applied with both select values before a run of random operands.

// File: rtl/asu_pkg.sv
package asu_pkg;
   // positions of the ten relations in the decoded vector
   localparam int REL_LT  = 0;
   localparam int REL_LE  = 1;
   localparam int REL_EQ  = 2;
   localparam int REL_NE  = 3;
   localparam int REL_GE  = 4;
   localparam int REL_GT  = 5;
   localparam int REL_LTU = 6;
   localparam int REL_LEU = 7;
   localparam int REL_GEU = 8;
   localparam int REL_GTU = 9;
   localparam int REL_COUNT = 10;

   typedef struct packed {
      logic z;
      logic n;
      logic c;
      logic v;
   } asu_flags_t;
endpackage

// File: rtl/asu_operand_cond.sv
module asu_operand_cond #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] b_in,
   input  logic             sub_sel,
   output logic [WIDTH-1:0] b_applied,
   output logic             carry_in
);
   always_comb begin
      b_applied = sub_sel ? ~b_in : b_in;
      carry_in  = sub_sel;
   end
endmodule

// File: rtl/asu_adder.sv
module asu_adder #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             carry_in,
   output logic [WIDTH-1:0] sum_out,
   output logic             carry_top_in,
   output logic             carry_out
);
   localparam int EXT = WIDTH + 1;
   logic [EXT-1:0] full_sum;

   always_comb begin
      full_sum     = {1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, carry_in};
      sum_out      = full_sum[WIDTH-1:0];
      carry_out    = full_sum[WIDTH];
      // carry arriving at the top column, recovered from its sum bit
      carry_top_in = a_in[WIDTH-1] ^ b_in[WIDTH-1] ^ full_sum[WIDTH-1];
   end
endmodule

// File: rtl/asu_flag_gen.sv
module asu_flag_gen
   import asu_pkg::*;
#(
   parameter int WIDTH           = 32,
   parameter bit OVF_FROM_CARRIES = 1'b1
) (
   input  logic [WIDTH-1:0] sum_in,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_applied,
   input  logic             carry_top_in,
   input  logic             carry_out,
   output asu_flags_t       flags
);
   localparam int MSB = WIDTH - 1;
   logic ovf;

   generate
      if (OVF_FROM_CARRIES) begin : g_ovf_carry
         always_comb ovf = carry_top_in ^ carry_out;
      end else begin : g_ovf_sign
         always_comb ovf = (a_in[MSB] == b_applied[MSB]) && (sum_in[MSB] != a_in[MSB]);
      end
   endgenerate

   always_comb begin
      flags.z = ~|sum_in;
      flags.n = sum_in[MSB];
      flags.c = carry_out;
      flags.v = ovf;
   end
endmodule

// File: rtl/asu_rel_decode.sv
module asu_rel_decode
   import asu_pkg::*;
(
   input  asu_flags_t           flags,
   output logic [REL_COUNT-1:0] rel
);
   logic s_less;
   logic u_less;

   always_comb begin
      s_less       = flags.n ^ flags.v;
      u_less       = ~flags.c;
      rel[REL_LT]  = s_less;
      rel[REL_LE]  = flags.z | s_less;
      rel[REL_EQ]  = flags.z;
      rel[REL_NE]  = ~flags.z;
      rel[REL_GE]  = ~s_less;
      rel[REL_GT]  = ~(flags.z | s_less);
      rel[REL_LTU] = u_less;
      rel[REL_LEU] = u_less | flags.z;
      rel[REL_GEU] = flags.c;
      rel[REL_GTU] = ~(u_less | flags.z);
   end
endmodule

// File: rtl/asu_addsub_cmp.sv
module asu_addsub_cmp
   import asu_pkg::*;
#(
   parameter int WIDTH            = 32,
   parameter bit OVF_FROM_CARRIES = 1'b1
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             sub_sel,
   output logic [WIDTH-1:0] sum,
   output logic             flag_z,
   output logic             flag_n,
   output logic             flag_c,
   output logic             flag_v,
   output logic             cmp_lt,
   output logic             cmp_le,
   output logic             cmp_eq,
   output logic             cmp_ne,
   output logic             cmp_ge,
   output logic             cmp_gt,
   output logic             cmp_ltu,
   output logic             cmp_leu,
   output logic             cmp_geu,
   output logic             cmp_gtu
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_width_bad
         $error("asu_addsub_cmp: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0]     b_app;
   logic                 cin;
   logic                 c_top_in;
   logic                 c_out;
   asu_flags_t           fl;
   logic [REL_COUNT-1:0] rel;

   asu_operand_cond #(.WIDTH(WIDTH)) u_cond (
      .b_in      (op_b),
      .sub_sel   (sub_sel),
      .b_applied (b_app),
      .carry_in  (cin)
   );

   asu_adder #(.WIDTH(WIDTH)) u_add (
      .a_in         (op_a),
      .b_in         (b_app),
      .carry_in     (cin),
      .sum_out      (sum),
      .carry_top_in (c_top_in),
      .carry_out    (c_out)
   );

   asu_flag_gen #(.WIDTH(WIDTH), .OVF_FROM_CARRIES(OVF_FROM_CARRIES)) u_flags (
      .sum_in       (sum),
      .a_in         (op_a),
      .b_applied    (b_app),
      .carry_top_in (c_top_in),
      .carry_out    (c_out),
      .flags        (fl)
   );

   asu_rel_decode u_rel (
      .flags (fl),
      .rel   (rel)
   );

   always_comb begin
      flag_z  = fl.z;
      flag_n  = fl.n;
      flag_c  = fl.c;
      flag_v  = fl.v;
      cmp_lt  = rel[REL_LT];
      cmp_le  = rel[REL_LE];
      cmp_eq  = rel[REL_EQ];
      cmp_ne  = rel[REL_NE];
      cmp_ge  = rel[REL_GE];
      cmp_gt  = rel[REL_GT];
      cmp_ltu = rel[REL_LTU];
      cmp_leu = rel[REL_LEU];
      cmp_geu = rel[REL_GEU];
      cmp_gtu = rel[REL_GTU];
   end

   // Invariants across the pieces, evaluated whenever any input moves.
   always_comb begin
      // R1
      add_inverse_chk: assert (sub_sel || ((sum - op_b) == op_a))
         else $error("add_inverse_chk: sum minus B is not A");
      // R2
      sub_inverse_chk: assert (!sub_sel || ((sum + op_b) == op_a))
         else $error("sub_inverse_chk: difference plus B is not A");
      // R6
      no_overflow_chk: assert (!flag_v ||
                               ((op_a[MSB] == (op_b[MSB] ^ sub_sel)) && (sum[MSB] != op_a[MSB])))
         else $error("no_overflow_chk: V set without a sign violation");
      // R5
      equal_sub_chk: assert (!(sub_sel && (op_a == op_b)) || (flag_z && flag_c && !flag_v))
         else $error("equal_sub_chk: A-A must give Z=1 C=1 V=0");
      // R7
      signed_excl_chk: assert ((cmp_lt ^ cmp_ge) && (cmp_eq ^ cmp_ne) && !(cmp_gt && cmp_le))
         else $error("signed_excl_chk: signed relations not exclusive");
      // R8
      unsigned_excl_chk: assert ((cmp_ltu ^ cmp_geu) && !(cmp_gtu && cmp_leu))
         else $error("unsigned_excl_chk: unsigned relations not exclusive");
   end
endmodule

// File: tb/tb_asu_addsub_cmp.sv
module tb_asu_addsub_cmp;
   localparam int W = 32;
   localparam longint MOD = 64'sd1 <<< W;
   localparam longint SMAX = (64'sd1 <<< (W - 1)) - 1;
   localparam longint SMIN = -(64'sd1 <<< (W - 1));

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic [W-1:0] op_a = '0;
   logic [W-1:0] op_b = '0;
   logic         sub_sel = 1'b0;
   logic [W-1:0] sum;
   logic fz, fn, fc, fv;
   logic lt, le, eq, ne, ge, gt, ltu, leu, geu, gtu;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   asu_addsub_cmp #(.WIDTH(W)) dut (
      .op_a(op_a), .op_b(op_b), .sub_sel(sub_sel), .sum(sum),
      .flag_z(fz), .flag_n(fn), .flag_c(fc), .flag_v(fv),
      .cmp_lt(lt), .cmp_le(le), .cmp_eq(eq), .cmp_ne(ne), .cmp_ge(ge), .cmp_gt(gt),
      .cmp_ltu(ltu), .cmp_leu(leu), .cmp_geu(geu), .cmp_gtu(gtu)
   );

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: a=%h b=%h sub=%0d actual=%0h expected=%0h",
                  tag, what, op_a, op_b, sub_sel, act, exp);
      end
   endtask

   task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
      longint ua, ub, sa, sb, full, exp_sum, sres;
      bit ez, en, ec, ev;
      @(negedge clk);
      op_a = a; op_b = b; sub_sel = s;
      #5;
      ua = longint'(a);
      ub = longint'(b);
      sa = (ua > SMAX) ? ua - MOD : ua;
      sb = (ub > SMAX) ? ub - MOD : ub;
      if (s) begin
         full = ua - ub;
         sres = sa - sb;
         ec   = (ua >= ub);
      end else begin
         full = ua + ub;
         sres = sa + sb;
         ec   = (full >= MOD);
      end
      exp_sum = ((full % MOD) + MOD) % MOD;
      ez = (exp_sum == 0);
      en = (exp_sum > SMAX);
      ev = (sres > SMAX) || (sres < SMIN);
      if (s) chk("R2", "sum", longint'(sum), exp_sum);
      else   chk("R1", "sum", longint'(sum), exp_sum);
      chk("R3", "Z", longint'(fz), longint'(ez));
      chk("R4", "N", longint'(fn), longint'(en));
      chk("R5", "C", longint'(fc), longint'(ec));
      chk("R6", "V", longint'(fv), longint'(ev));
      if (s) begin
         chk("R7", "lt", longint'(lt), longint'(sa < sb));
         chk("R7", "le", longint'(le), longint'(sa <= sb));
         chk("R7", "eq", longint'(eq), longint'(sa == sb));
         chk("R7", "ne", longint'(ne), longint'(sa != sb));
         chk("R7", "ge", longint'(ge), longint'(sa >= sb));
         chk("R7", "gt", longint'(gt), longint'(sa > sb));
         chk("R8", "ltu", longint'(ltu), longint'(ua < ub));
         chk("R8", "leu", longint'(leu), longint'(ua <= ub));
         chk("R8", "geu", longint'(geu), longint'(ua >= ub));
         chk("R8", "gtu", longint'(gtu), longint'(ua > ub));
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
         finish_run();
      end
   end

   initial begin
      logic [W-1:0] corner [6];
      corner[0] = '0;
      corner[1] = {{(W-1){1'b0}}, 1'b1};
      corner[2] = {1'b0, {(W-1){1'b1}}};
      corner[3] = {1'b1, {(W-1){1'b0}}};
      corner[4] = '1;
      corner[5] = {(W/2){2'b10}};

      // R9: quiescent state with zero operands, addition, no clock involved
      #5;
      chk("R9", "sum", longint'(sum), 0);
      chk("R9", "Z", longint'(fz), 1);
      chk("R9", "NCV", longint'({fn, fc, fv}), 0);

      // R9: outputs follow an input change with no intervening edge
      op_a = corner[2]; op_b = corner[1]; sub_sel = 1'b0;
      #1;
      chk("R9", "sum_settle", longint'(sum), longint'(corner[3]));
      chk("R6", "V_settle", longint'(fv), 1);

      // R5: all ones plus one wraps to zero with carry set
      apply('1, corner[1], 1'b0);
      // R6: most negative minus one overflows
      apply(corner[3], corner[1], 1'b1);

      for (int i = 0; i < 6; i++)
         for (int j = 0; j < 6; j++)
            for (int s = 0; s < 2; s++)
               apply(corner[i], corner[j], s[0]);

      for (int k = 0; k < 400; k++)
         apply(W'($urandom), W'($urandom), k[0]);

      // equal random operands exercise EQ, LE, GE, LEU, GEU together
      for (int k = 0; k < 20; k++) begin
         logic [W-1:0] r;
         r = W'($urandom);
         apply(r, r, 1'b1);
      end

      finish_run();
   end
endmodule